// File: doc/BRIEF.md
# Instruction Packer for 48-bit Fetches over 32-bit Memory

The block lets a sequencer that fetches 48-bit instructions execute straight from a bank of 32-bit memory that is reached through a 16-bit external data bus. No word bits are left unused: two instructions fill three memory words. An instruction address is translated into a 32-bit word address plus a half-of-word selector. The block then issues three 16-bit reads in ascending order, stitches the returned halfwords into one 48-bit instruction and hands it back with a one-cycle acknowledge.

On the fetch side, a request is taken only while the block reports it is ready. The memory side is a synchronous read port. It gets a one-cycle request with an address and answers some cycles later with a one-cycle data valid. The latency may differ from beat to beat. Only one beat is outstanding at a time.

Top module: `instr_packer`

## Requirements
- R1: The first halfword of instruction address A is h = 2*WORD_BASE + 3*(A - INSTR_BASE). `mem_word_addr` carries h>>1 and `mem_hi` carries h[0], where 0 is the low half and 1 is the high half. With the default bases, address 0x0020_0000 reads word 0x0030_0000 low half first, and address 0x0020_0001 begins at word 0x0030_0001 high half.
- R2: Each fetch issues exactly three single-cycle `mem_req` pulses, at halfwords h, h+1 and h+2 in that order. The next request is raised only after the data of the previous one has returned with `mem_valid`.
- R3: The halfword returned first lands in `fetch_instr[15:0]`, the second in `[31:16]` and the third in `[47:32]`.
- R4: `fetch_ack` is high for exactly one cycle, with the complete instruction on `fetch_instr`. `fetch_ready` drops in the cycle after a request is accepted and comes back in the cycle after the acknowledge.
- R5: A `fetch_req` while `fetch_ready` is low has no effect. No extra acknowledge and no extra memory request follow, and the instruction in flight is not altered.
- R6: A `mem_valid` while no beat is outstanding is ignored. This includes any valid in idle and any valid in the cycle that carries `mem_req`.
- R7: The result does not depend on read latency. Any latency of one or more cycles per beat gives the same instruction.
- R8: While `rst_n` is low the block is idle: `fetch_ready`=1, `fetch_ack`=0 and `mem_req`=0. A fetch that is cut short by reset is discarded and never acknowledged.
- R9: A run of 2048 instructions from INSTR_BASE ends at word WORD_BASE+0xBFF, high half. Instruction 2048 starts at word WORD_BASE+0xC00, low half, so data placed 3072 words above the base does not overlap the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request, taken when fetch_ready is high |
| fetch_addr | input | IAW | Instruction address of the request |
| fetch_ready | output | 1 | Block is idle and can accept a request |
| fetch_ack | output | 1 | One-cycle strobe: fetch_instr is complete |
| fetch_instr | output | INSTR_W | Assembled 48-bit instruction |
| mem_req | output | 1 | One-cycle halfword read request |
| mem_word_addr | output | WAW | 32-bit word address of the read |
| mem_hi | output | 1 | Half select: 0 low half, 1 high half |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | BEAT_W | Read data halfword |

## Verification
The hardest situations to reach are stray events that land while a fetch is in a particular phase. These are a new request arriving while the beats are still in flight, a data valid arriving when nothing is outstanding, and a reset arriving between the second and third beat. The bench reaches them with a memory model whose latency is set per scenario. A long latency keeps the block busy while the bench holds a second request on the port with a different address. The bench also asserts an injected valid while the block sits idle. In another scenario it pulls reset low mid-fetch and lets the model's late answer arrive afterwards, then checks that no acknowledge appears and that the next fetch is exact. The odd-offset and end-of-run addresses exercise the half-word start position.

// File: rtl/ipk_pkg.sv
package ipk_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/ipk_addr_map.sv
// Instruction address to first-halfword index: three halfwords per instruction.
module ipk_addr_map #(
  parameter int              IAW        = 32,
  parameter int              WAW        = 32,
  parameter int              BEATS      = 3,
  parameter logic [IAW-1:0]  INSTR_BASE = 32'h0020_0000,
  parameter logic [WAW-1:0]  WORD_BASE  = 32'h0030_0000
) (
  input  logic [IAW-1:0] instr_addr,
  output logic [WAW:0]   start_hw
);
  localparam int HWW = WAW + 1;
  localparam logic [HWW-1:0] BASE_HW = {WORD_BASE, 1'b0};

  logic [IAW-1:0] offset;
  logic [HWW-1:0] offset_ext;

  always_comb begin
    offset     = instr_addr - INSTR_BASE;
    offset_ext = HWW'(offset);
    start_hw   = BASE_HW + offset_ext * HWW'(BEATS);
  end
endmodule

// File: rtl/ipk_seq.sv
// Beat sequencer: one outstanding halfword read at a time.
module ipk_seq
  import ipk_pkg::*;
#(
  parameter int HWW   = 33,
  parameter int BEATS = 3,
  localparam int IW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fetch_req,
  input  logic [HWW-1:0] start_hw,
  input  logic           mem_valid,
  output logic           ready,
  output logic           ack,
  output logic           mem_req,
  output logic [HWW-1:0] req_hw,
  output logic           cap_en,
  output logic [IW-1:0]  cap_idx
);
  localparam logic [IW-1:0] LAST = IW'(BEATS - 1);

  seq_state_e     state_q, state_d;
  logic [HWW-1:0] hw_q, hw_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic           start, last_beat, adv_en;

  always_comb begin
    start     = fetch_req && (state_q == S_IDLE);
    last_beat = (idx_q == LAST);
    cap_en    = (state_q == S_WAIT) && mem_valid;
    adv_en    = start || (cap_en && !last_beat);
    state_d   = state_q;
    hw_d      = hw_q;
    idx_d     = idx_q;
    case (state_q)
      S_IDLE:  if (start) begin
                 state_d = S_ISSUE;
                 hw_d    = start_hw;
                 idx_d   = '0;
               end
      S_ISSUE: state_d = S_WAIT;
      S_WAIT:  if (mem_valid) begin
                 if (last_beat) begin
                   state_d = S_DONE;
                 end else begin
                   state_d = S_ISSUE;
                   hw_d    = hw_q + HWW'(1);
                   idx_d   = idx_q + IW'(1);
                 end
               end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q  <= '0;
      idx_q <= '0;
    end else if (adv_en) begin
      hw_q  <= hw_d;
      idx_q <= idx_d;
    end
  end

  always_comb begin
    ready   = (state_q == S_IDLE);
    ack     = (state_q == S_DONE);
    mem_req = (state_q == S_ISSUE);
    req_hw  = hw_q;
    cap_idx = idx_q;
  end

  // R4: a completed fetch is followed by an idle cycle that is not another ack
  p_ack_then_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!ack && ready));
endmodule

// File: rtl/ipk_assemble.sv
// Halfword lanes; beat k lands in bits [16k+15:16k].
module ipk_assemble #(
  parameter int BEAT_W = 16,
  parameter int BEATS  = 3,
  localparam int IW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [IW-1:0]           cap_idx,
  input  logic [BEAT_W-1:0]       beat_data,
  output logic [BEATS*BEAT_W-1:0] instr
);
  for (genvar g = 0; g < BEATS; g++) begin : g_lane
    logic [BEAT_W-1:0] lane_q;
    logic              lane_en;

    always_comb lane_en = cap_en && (cap_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (lane_en) begin
        lane_q <= beat_data;
      end
    end

    always_comb instr[g*BEAT_W +: BEAT_W] = lane_q;
  end
endmodule

// File: rtl/instr_packer.sv
module instr_packer #(
  parameter int              IAW        = 32,
  parameter int              WAW        = 32,
  parameter int              INSTR_W    = 48,
  parameter int              BEAT_W     = 16,
  parameter logic [IAW-1:0]  INSTR_BASE = 32'h0020_0000,
  parameter logic [WAW-1:0]  WORD_BASE  = 32'h0030_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_req,
  input  logic [IAW-1:0]     fetch_addr,
  output logic               fetch_ready,
  output logic               fetch_ack,
  output logic [INSTR_W-1:0] fetch_instr,
  output logic               mem_req,
  output logic [WAW-1:0]     mem_word_addr,
  output logic               mem_hi,
  input  logic               mem_valid,
  input  logic [BEAT_W-1:0]  mem_data
);
  localparam int BEATS = INSTR_W / BEAT_W;
  localparam int HWW   = WAW + 1;
  localparam int IW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int CW    = $clog2(BEATS + 1);

  logic [HWW-1:0] start_hw, req_hw;
  logic           cap_en;
  logic [IW-1:0]  cap_idx;

  ipk_addr_map #(
    .IAW(IAW), .WAW(WAW), .BEATS(BEATS),
    .INSTR_BASE(INSTR_BASE), .WORD_BASE(WORD_BASE)
  ) u_map (
    .instr_addr (fetch_addr),
    .start_hw   (start_hw)
  );

  ipk_seq #(.HWW(HWW), .BEATS(BEATS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_req (fetch_req),
    .start_hw  (start_hw),
    .mem_valid (mem_valid),
    .ready     (fetch_ready),
    .ack       (fetch_ack),
    .mem_req   (mem_req),
    .req_hw    (req_hw),
    .cap_en    (cap_en),
    .cap_idx   (cap_idx)
  );

  ipk_assemble #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .cap_idx   (cap_idx),
    .beat_data (mem_data),
    .instr     (fetch_instr)
  );

  always_comb begin
    mem_word_addr = req_hw[HWW-1:1];
    mem_hi        = req_hw[0];
  end

  // Observation state for the checks below, kept apart from the sequencer.
  logic           pend_q;
  logic [CW-1:0]  got_q;
  logic [HWW-1:0] prev_hw_q;
  logic           accept;

  always_comb accept = fetch_req && fetch_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      got_q     <= '0;
      prev_hw_q <= '0;
    end else begin
      if (mem_req) begin
        pend_q    <= 1'b1;
        prev_hw_q <= {mem_word_addr, mem_hi};
      end else if (pend_q && mem_valid) begin
        pend_q <= 1'b0;
      end
      if (accept) begin
        got_q <= '0;
      end else if (pend_q && mem_valid && !mem_req) begin
        got_q <= got_q + CW'(1);
      end
    end
  end

  // R2: never a second read while one is still owed
  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !pend_q);

  // R2: later beats step up by one halfword
  p_beat_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && got_q != '0) |-> ({mem_word_addr, mem_hi} == prev_hw_q + HWW'(1)));

  // R3: acknowledge only once every beat has come back
  p_ack_all_beats_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ack |-> (got_q == CW'(BEATS)));

  // R5: an accepted request makes the block busy
  p_busy_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !fetch_ready);
endmodule

// File: tb/sim_instr_packer.sv
module sim_instr_packer;
  localparam int CLK_NS = 10;
  localparam logic [31:0] IB = 32'h0020_0000;
  localparam logic [31:0] WB = 32'h0030_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_ready, fetch_ack, mem_req, mem_hi;
  logic [47:0] fetch_instr;
  logic [31:0] mem_word_addr;
  logic        mem_valid;
  logic [15:0] mem_data;

  logic        mdl_valid = 1'b0;
  logic [15:0] mdl_data = '0;
  logic        inj_valid = 1'b0;
  int          lat_cfg = 1;
  int          nreq = 0;
  int          ack_cnt = 0;
  logic [32:0] logh [0:7];
  int          errors = 0;
  int          checks = 0;

  assign mem_valid = mdl_valid | inj_valid;
  assign mem_data  = inj_valid ? 16'hDEAD : mdl_data;

  instr_packer u0 (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .fetch_ack(fetch_ack), .fetch_instr(fetch_instr),
    .mem_req(mem_req), .mem_word_addr(mem_word_addr), .mem_hi(mem_hi),
    .mem_valid(mem_valid), .mem_data(mem_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [15:0] memf(input logic [32:0] h);
    return h[15:0] ^ 16'h5A3C ^ {h[23:16], 8'h00};
  endfunction

  // Memory model: samples requests at negedges, answers lat_cfg negedges later.
  initial begin
    logic [32:0] h;
    forever begin
      @(negedge clk);
      mdl_valid = 1'b0;
      if (mem_req && rst_n) begin
        h = {mem_word_addr, mem_hi};
        if (nreq < 8) logh[nreq] = h;
        nreq++;
        repeat (lat_cfg) @(negedge clk);
        mdl_valid = 1'b1;
        mdl_data  = memf(h);
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (fetch_ack) ack_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] first_hw(input logic [31:0] a);
    return {WB, 1'b0} + 33'(a - IB) * 33'd3;
  endfunction

  function automatic logic [47:0] exp_instr(input logic [31:0] a);
    logic [32:0] h;
    h = first_hw(a);
    return {memf(h + 33'd2), memf(h + 33'd1), memf(h)};
  endfunction

  task automatic wait_ack();
    int n;
    n = 0;
    while (!fetch_ack && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Plain fetch: mapping, beat order, assembly, handshake.
  task automatic t_fetch(input logic [31:0] a, input int lat, input string req);
    logic [32:0] h;
    h = first_hw(a);
    lat_cfg = lat;
    nreq = 0;
    @(negedge clk);
    fetch_req = 1'b1;
    fetch_addr = a;
    @(negedge clk);
    fetch_req = 1'b0;
    chk(!fetch_ready, {req, " R4 busy"}, 64'(fetch_ready), 64'd0);
    wait_ack();
    chk(fetch_ack, {req, " R4 ack seen"}, 64'(fetch_ack), 64'd1);
    chk(fetch_instr == exp_instr(a), {req, " R3 instr"}, 64'(fetch_instr), 64'(exp_instr(a)));
    chk(nreq == 3, {req, " R2 beats"}, 64'(nreq), 64'd3);
    chk(logh[0] == h && logh[1] == h + 33'd1 && logh[2] == h + 33'd2,
        {req, " R1 R2 addresses"}, 64'(logh[0]), 64'(h));
    @(negedge clk);
    chk(!fetch_ack && fetch_ready, {req, " R4 single-cycle ack"}, 64'({fetch_ack, fetch_ready}), 64'b01);
  endtask

  // R1 R9: word/half positions at the corners of a 2048-instruction run.
  task automatic t_map_corners();
    t_fetch(IB, 1, "base");
    chk(logh[0] == {WB, 1'b0}, "R1 base word low half", 64'(logh[0]), 64'({WB, 1'b0}));
    t_fetch(IB + 32'd1, 2, "odd");
    chk(logh[0] == {WB + 32'd1, 1'b1}, "R1 odd starts high half", 64'(logh[0]), 64'({WB + 32'd1, 1'b1}));
    t_fetch(IB + 32'd2047, 1, "last");
    chk(logh[2] == {WB + 32'h0BFF, 1'b1}, "R9 run ends at 0xBFF high", 64'(logh[2]), 64'({WB + 32'h0BFF, 1'b1}));
    t_fetch(IB + 32'd2048, 1, "next");
    chk(logh[0] == {WB + 32'h0C00, 1'b0}, "R9 instr 2048 at 0xC00 low", 64'(logh[0]), 64'({WB + 32'h0C00, 1'b0}));
  endtask

  // R7: same instruction under different latencies.
  task automatic t_latency();
    t_fetch(IB + 32'd77, 1, "R7 lat1");
    t_fetch(IB + 32'd77, 4, "R7 lat4");
    t_fetch(IB + 32'd77, 9, "R7 lat9");
  endtask

  // R5: request held with another address while busy.
  task automatic t_busy_req();
    int a0;
    a0 = ack_cnt;
    lat_cfg = 6;
    nreq = 0;
    @(negedge clk);
    fetch_req = 1'b1;
    fetch_addr = IB + 32'd10;
    @(negedge clk);
    fetch_addr = IB + 32'd500;
    repeat (4) @(negedge clk);
    fetch_req = 1'b0;
    wait_ack();
    chk(fetch_instr == exp_instr(IB + 32'd10), "R5 in-flight instr kept", 64'(fetch_instr), 64'(exp_instr(IB + 32'd10)));
    repeat (30) @(negedge clk);
    chk(ack_cnt == a0 + 1, "R5 one ack only", 64'(ack_cnt - a0), 64'd1);
    chk(nreq == 3, "R5 no extra reads", 64'(nreq), 64'd3);
  endtask

  // R6: stray valid while idle.
  task automatic t_stray_valid();
    int a0;
    a0 = ack_cnt;
    nreq = 0;
    @(negedge clk);
    inj_valid = 1'b1;
    @(negedge clk);
    inj_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(ack_cnt == a0 && fetch_ready && nreq == 0, "R6 stray valid ignored",
        64'({ack_cnt - a0, nreq}), 64'd0);
    t_fetch(IB + 32'd5, 2, "R6 after stray");
  endtask

  // R8: reset in the middle of a fetch.
  task automatic t_reset_mid();
    int a0;
    a0 = ack_cnt;
    lat_cfg = 3;
    nreq = 0;
    @(negedge clk);
    fetch_req = 1'b1;
    fetch_addr = IB + 32'd33;
    @(negedge clk);
    fetch_req = 1'b0;
    while (nreq < 2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(fetch_ready && !fetch_ack && !mem_req, "R8 idle in reset",
        64'({fetch_ready, fetch_ack, mem_req}), 64'b100);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(ack_cnt == a0, "R8 partial fetch discarded", 64'(ack_cnt - a0), 64'd0);
    t_fetch(IB + 32'd34, 2, "R8 after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(fetch_ready && !fetch_ack && !mem_req, "R8 reset state",
        64'({fetch_ready, fetch_ack, mem_req}), 64'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_map_corners();
    t_latency();
    t_busy_req();
    t_stray_valid();
    t_reset_mid();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule